// File: doc/BRIEF.md
# Asynchronous SRAM Behavioural Emulator

This block emulates a byte-wide static RAM that is driven by asynchronous active-low strobes (select, write, output-enable), an address bus and a split data bus. Every strobe, address and data input passes through a two-flop synchroniser into the emulator clock. The block then decodes one of four operating modes from the sampled strobes. A write happens while select and write strobe are both low. It is committed to an inferred synchronous array when that overlap ends, using the address and data sampled on the last clock in which the overlap was still active. Read data comes from the array at the sampled address through a register.

The bidirectional pad is modelled as three signals: a data input, a data output, and an output-enable that the chip-level pad cell uses. The output-enable is high only in the read mode. A standby flag is high whenever the sampled select strobe is high, which models the automatic power-down state. The array depth is `2**ADDR_W`. A full 32768 x 8 part is built with `ADDR_W = 15`. The default parameter keeps the array small.

Top module: `sram_emu`

## Requirements
- R1: While reset is asserted and after its release with idle strobes, `standby` is 1 and `drive_en` is 0; `rdata` is 0 during reset.
- R2: When the sampled `sel_n` is 1, `standby` is 1 and `drive_en` is 0 whatever `wr_n` and `oe_n` do, and a low `wr_n` writes nothing.
- R3: With `sel_n`=0, `wr_n`=1 and `oe_n`=0, `drive_en` is 1 and `rdata` equals the byte stored at `addr`, including the highest address.
- R4: With `sel_n`=0 and `wr_n`=0, a write is performed whether `oe_n` is 0 or 1, and `drive_en` stays 0 throughout.
- R5: With `sel_n`=0, `wr_n`=1 and `oe_n`=1, `drive_en` is 0 and `standby` is 0.
- R6: A write ends when either `wr_n` or `sel_n` rises, and the data is stored at the same point in both cases. Each overlap commits exactly one write.
- R7: The committed address and data are the values present just before the terminating rise. If `addr` or `wdata` changes together with the rise, the new values are not stored.
- R8: When `sel_n` and `wr_n` rise together, `drive_en` stays 0 and the write is still committed.
- R9: An input change is visible at the outputs after the third rising clock edge that follows it: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low chip select strobe (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| oe_n | input | 1 | Active-low output enable strobe (asynchronous) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data-pin input side |
| rdata | output | DATA_W | Data-pin output side, valid while drive_en is 1 |
| drive_en | output | 1 | Enables the external pad driver |
| standby | output | 1 | Deselected / power-down indication |

## Verification
The hardest case to reach is a write whose terminating strobe rises on the same clock as a change in address and data. In that case the committed values must be the ones from before the change. The stimulus first fills the target location with a known byte. It then holds a write long enough to pass the synchroniser, and in a single drive it raises the write strobe and changes both address and data. Reading back both addresses shows which pair was stored. A second directed case raises select and write together. It watches `drive_en` on every cycle of the transition and then confirms the write landed.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } emu_mode_e;

  function automatic emu_mode_e decode_mode(input logic sel_n, input logic wr_n,
                                            input logic oe_n);
    if (sel_n)      return MODE_OFF;
    else if (!wr_n) return MODE_WRITE;
    else if (!oe_n) return MODE_READ;
    else            return MODE_IDLE;
  endfunction

endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stg[i-1].r;
      end
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_sel_n,
  input  logic              s_wr_n,
  input  logic              s_oe_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              drive_en,
  output logic              standby
);

  emu_mode_e         mode;
  logic              wr_act;
  logic              wr_act_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              drive_d, drive_q;
  logic              stby_d, stby_q;

  // next-state logic
  always_comb begin
    mode    = decode_mode(s_sel_n, s_wr_n, s_oe_n);
    wr_act  = (mode == MODE_WRITE);
    addr_d  = addr_q;
    data_d  = data_q;
    if (wr_act) begin
      addr_d = s_addr;
      data_d = s_wdata;
    end
    drive_d = (mode == MODE_READ);
    stby_d  = (mode == MODE_OFF);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      drive_q  <= 1'b0;
      stby_q   <= 1'b1;
    end else begin
      wr_act_q <= wr_act;
      addr_q   <= addr_d;
      data_q   <= data_d;
      drive_q  <= drive_d;
      stby_q   <= stby_d;
    end
  end

  assign wr_en    = wr_act_q & ~wr_act;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign drive_en = drive_q;
  assign standby  = stby_q;

  // R6
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |=> !drive_en);

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;

  // R4
  commit_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && !$past(wr_en) && ($past(rd_addr) == $past(wr_addr, 2)))
      |-> (rd_data == $past(wr_data, 2)));

endmodule

// File: rtl/sram_emu.sv
module sram_emu #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_en,
  output logic              standby
);

  localparam int unsigned        BUS_W   = 3 + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0]   BUS_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic              rst_sync_n;
  logic [BUS_W-1:0]  bus_in, bus_s;
  logic              s_sel_n, s_wr_n, s_oe_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  sram_emu_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  assign bus_in = {sel_n, wr_n, oe_n, addr, wdata};

  sram_emu_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(bus_in), .q(bus_s)
  );

  assign {s_sel_n, s_wr_n, s_oe_n, s_addr, s_wdata} = bus_s;

  sram_emu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .s_sel_n(s_sel_n), .s_wr_n(s_wr_n), .s_oe_n(s_oe_n),
    .s_addr(s_addr), .s_wdata(s_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .drive_en(drive_en), .standby(standby)
  );

  sram_emu_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(s_addr), .rd_data(rdata)
  );

  // R2
  standby_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    standby |-> !drive_en);

endmodule

// File: tb/sram_emu_tb.sv
module sram_emu_tb;

  localparam int AW = 11;
  localparam int DW = 8;

  typedef struct packed {
    logic          sel;
    logic          wr;
    logic          oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          en;
    logic          st;
    logic [DW-1:0] q;
    logic          chkq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 11'h005, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0},  // R4 write
    '{1'b0, 1'b1, 1'b1, 11'h005, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0},  // R5/R6 wr ends
    '{1'b0, 1'b1, 1'b0, 11'h005, 8'h00, 1'b1, 1'b0, 8'hA5, 1'b1},  // R3 read
    '{1'b0, 1'b0, 1'b0, 11'h009, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0},  // R4 oe low
    '{1'b0, 1'b1, 1'b0, 11'h009, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1},  // R4 readback
    '{1'b1, 1'b0, 1'b0, 11'h009, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b0},  // R2 deselect
    '{1'b1, 1'b1, 1'b0, 11'h009, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b0},  // R2
    '{1'b0, 1'b1, 1'b0, 11'h009, 8'h00, 1'b1, 1'b0, 8'h3C, 1'b1},  // R2 unchanged
    '{1'b0, 1'b1, 1'b0, 11'h005, 8'h00, 1'b1, 1'b0, 8'hA5, 1'b1},  // R3
    '{1'b0, 1'b0, 1'b1, 11'h7FF, 8'h81, 1'b0, 1'b0, 8'h00, 1'b0},  // R6 write top
    '{1'b1, 1'b0, 1'b1, 11'h7FF, 8'h81, 1'b0, 1'b1, 8'h00, 1'b0},  // R6 sel ends
    '{1'b0, 1'b1, 1'b0, 11'h7FF, 8'h00, 1'b1, 1'b0, 8'h81, 1'b1}   // R3/R6 top addr
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          drive_en, standby;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_emu #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .drive_en(drive_en),
    .standby(standby)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic o,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk);
    #2;
    sel_n = s; wr_n = w; oe_n = o; addr = a; wdata = d;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1 during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 standby in reset", {7'd0, standby}, 8'd1);
    chk("R1 drive_en in reset", {7'd0, drive_en}, 8'd0);
    chk("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R1 standby after release", {7'd0, standby}, 8'd1);
    chk("R1 drive_en after release", {7'd0, drive_en}, 8'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sel, VEC[i].wr, VEC[i].oe, VEC[i].a, VEC[i].d);
      settle();
      chk($sformatf("R2-R6 vec%0d drive_en", i), {7'd0, drive_en}, {7'd0, VEC[i].en});
      chk($sformatf("R2/R5 vec%0d standby", i), {7'd0, standby}, {7'd0, VEC[i].st});
      if (VEC[i].chkq) chk($sformatf("R3 vec%0d rdata", i), rdata, VEC[i].q);
    end

    // R9 latency: output enable turns on after the third edge
    drive(1'b0, 1'b1, 1'b1, 11'h005, 8'h00);
    settle();
    drive(1'b0, 1'b1, 1'b0, 11'h005, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 not yet after two edges", {7'd0, drive_en}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 on after three edges", {7'd0, drive_en}, 8'd1);

    // R7 terminating-edge capture
    drive(1'b0, 1'b0, 1'b1, 11'h013, 8'h44);
    settle();
    drive(1'b0, 1'b1, 1'b1, 11'h013, 8'h44);
    settle();
    drive(1'b0, 1'b0, 1'b1, 11'h012, 8'h11);
    settle();
    drive(1'b0, 1'b1, 1'b1, 11'h013, 8'h22);
    settle();
    drive(1'b0, 1'b1, 1'b0, 11'h012, 8'h00);
    settle();
    chk("R7 old address keeps old data", rdata, 8'h11);
    drive(1'b0, 1'b1, 1'b0, 11'h013, 8'h00);
    settle();
    chk("R7 new address untouched", rdata, 8'h44);

    // R8 simultaneous rise of select and write
    drive(1'b0, 1'b0, 1'b0, 11'h020, 8'h5A);
    settle();
    drive(1'b1, 1'b1, 1'b0, 11'h020, 8'h5A);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk($sformatf("R8 drive_en off cycle %0d", k), {7'd0, drive_en}, 8'd0);
    end
    drive(1'b0, 1'b1, 1'b0, 11'h020, 8'h00);
    settle();
    chk("R8 write committed", rdata, 8'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule